// File: doc/BRIEF.md
# Dual Comparator Change-Detect Interrupt Unit

This unit is the digital side of a pair of analog voltage comparators. Each comparator's raw output is brought into the clock domain through a two-flop synchronizer. The unit watches the synchronized level for a toggle in either direction and latches a per-channel change flag. It combines the flags that software has armed into one shared interrupt request. Each channel can also drive its level onto a dedicated pin when that channel's pin-enable bit is set.

A small power-mode state machine tracks the processor's sleep state and has four states: `PM_RUN`, `PM_IDLE`, `PM_DOWN` and `PM_TOTAL`. The transitions are:
- `PM_RUN` to `PM_IDLE`, `PM_DOWN` or `PM_TOTAL` on a sleep strobe, chosen by the sleep code.
- `PM_IDLE` or `PM_DOWN` back to `PM_RUN` on a comparator wake request or on an external wake.
- `PM_TOTAL` back to `PM_RUN` on an external wake only.

In `PM_TOTAL` both comparators are forced inactive and all interrupt and wake activity is suppressed. Because the main clock is assumed stopped in `PM_DOWN`, the wake request is formed without a clock: it compares the raw comparator inputs against the last latched levels.

Software reaches the unit through a flat register file. There is one register per channel, followed by one global register that holds a single bit which switches both comparators off.

Top module: `cmpchg_unit`

## Requirements
- R1: A toggle of a channel's raw input, held stable, sets that channel's flag (channel register bit 3) on the third rising clock edge after the toggle and not before. Rising and falling toggles behave alike. The channel must be active: its enable (bit 0) is 1, the global off bit is 0 and the state is not `PM_TOTAL`.
- R2: The flag is set whether or not the channel's interrupt enable (bit 2) is 1, so software can poll it.
- R3: `irq` is 1 exactly when some channel has both its flag and its interrupt enable at 1 and the state is not `PM_TOTAL`. It stays 1 until that flag is cleared.
- R4: A register write whose bit 3 is 0 clears that channel's flag, and a write whose bit 3 is 1 leaves the flag unchanged. If a change is detected in the same cycle as a clearing write, the flag stays set.
- R5: While the global off bit (bit 0 of the register at address 2) is 1, neither channel sets its flag and both pins are 0.
- R6: Enabling a channel, clearing the off bit or leaving `PM_TOTAL` never sets a flag by itself while the raw input is steady.
- R7: `cmp_pin[i]` equals the channel's synchronized level when the pin enable (bit 1) is 1 and the channel is active, and is 0 otherwise.
- R8: From `PM_RUN`, a one-cycle `sleep_go` moves the state to `PM_IDLE`, `PM_DOWN` or `PM_TOTAL` for `sleep_kind` 1, 2 or 3. A `sleep_kind` of 0 is ignored. `pm_state` reports the state codes 0, 1, 2 and 3.
- R9: In `PM_IDLE` or `PM_DOWN`, `wake_req` rises in the same cycle as a raw input differs from its latched level on an active channel whose interrupt enable is 1. `wake_req` is also 1 while `irq` is 1. Either a wake request or `ext_wake` returns the state to `PM_RUN` at the next edge.
- R10: In `PM_TOTAL` no flag is set, `irq` and `wake_req` are 0, and only `ext_wake` leaves the state.
- R11: Reading a channel register returns enable, pin enable and interrupt enable in bits 0 to 2, the flag in bit 3 and the synchronized level in bit 4. Reading address 2 returns the off bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmp_raw | input | NCH | Raw comparator outputs (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: channels 0..NCH-1, global at NCH |
| wr_data | input | 4 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 5 | Read data |
| sleep_go | input | 1 | One-cycle request to enter a sleep state |
| sleep_kind | input | 2 | Sleep code: 1 idle, 2 down, 3 total |
| ext_wake | input | 1 | Wake from any other source |
| irq | output | 1 | Shared interrupt request |
| wake_req | output | 1 | Clock-free wake request while sleeping |
| pm_state | output | 2 | Current power state code |
| cmp_pin | output | NCH | Gated comparator pin outputs |

## Verification
Two functions can meet in one cycle: detecting a change, and software clearing the same flag with a write. The bench toggles a raw input and counts two edges so that the synchronized level is exactly one edge away from being latched. It then places a clearing write on the very edge where the change is detected. The flag is read back afterwards and must be set; a plain clear with no change must leave it 0. A second meeting point is a pending flag at the moment of entering `PM_TOTAL`. In that case `irq` must drop while the state is held and return when the state is left.

// File: rtl/cmpchg_pkg.sv
package cmpchg_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_DOWN  = 2'd2,
        PM_TOTAL = 2'd3
    } pm_state_t;

    // channel register bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_OE   = 1;
    localparam int BIT_IE   = 2;
    localparam int BIT_FLAG = 3;
    localparam int BIT_LVL  = 4;

    localparam int WR_W = BIT_FLAG + 1;
    localparam int RD_W = BIT_LVL + 1;

    typedef struct packed {
        logic ie;
        logic oe;
        logic en;
    } ch_cfg_t;
endpackage

// File: rtl/cmpchg_sync.sv
module cmpchg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpchg_chan.sv
module cmpchg_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic lvl,
    input  logic active,
    input  logic clr,
    output logic flag,
    output logic wake_src
);
    logic prev;
    logic change;

    // prev follows the level at all times, so turning a channel on
    // compares against a fresh sample and sees no stale difference
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign change = active & (lvl ^ prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (change) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // clock-free path: raw input against last latched level
    assign wake_src = active & (raw ^ prev);
endmodule

// File: rtl/cmpchg_regs.sv
module cmpchg_regs
    import cmpchg_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    input  logic [NCH-1:0]  flag_in,
    input  logic [NCH-1:0]  lvl_in,
    output logic [RD_W-1:0] rd_data,
    output ch_cfg_t         cfg [NCH],
    output logic [NCH-1:0]  clr,
    output logic            all_off
);
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic hit;
            assign hit    = wr_en && (wr_addr == AW'(i));
            assign clr[i] = hit && !wr_data[BIT_FLAG];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg[i] <= '0;
                end else if (hit) begin
                    cfg[i].en <= wr_data[BIT_EN];
                    cfg[i].oe <= wr_data[BIT_OE];
                    cfg[i].ie <= wr_data[BIT_IE];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  all_off <= 1'b0;
        else if (wr_en && (wr_addr == AW'(NCH)))     all_off <= wr_data[0];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data[BIT_EN]   = cfg[i].en;
                rd_data[BIT_OE]   = cfg[i].oe;
                rd_data[BIT_IE]   = cfg[i].ie;
                rd_data[BIT_FLAG] = flag_in[i];
                rd_data[BIT_LVL]  = lvl_in[i];
            end
        end
        if (rd_addr == AW'(NCH)) rd_data[0] = all_off;
    end
endmodule

// File: rtl/cmpchg_pwr.sv
module cmpchg_pwr
    import cmpchg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_go,
    input  logic [1:0] sleep_kind,
    input  logic       wake_any,
    input  logic       ext_wake,
    output pm_state_t  state,
    output logic       sleeping,
    output logic       in_total
);
    pm_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN: begin
                if (sleep_go) begin
                    unique case (sleep_kind)
                        2'd1:    nxt = PM_IDLE;
                        2'd2:    nxt = PM_DOWN;
                        2'd3:    nxt = PM_TOTAL;
                        default: nxt = PM_RUN;
                    endcase
                end
            end
            PM_IDLE:  if (wake_any || ext_wake) nxt = PM_RUN;
            PM_DOWN:  if (wake_any || ext_wake) nxt = PM_RUN;
            PM_TOTAL: if (ext_wake)             nxt = PM_RUN;
            default:  nxt = PM_RUN;
        endcase
    end

    always_comb begin
        sleeping = 1'b0;
        in_total = 1'b0;
        unique case (state)
            PM_RUN:   ;
            PM_IDLE:  sleeping = 1'b1;
            PM_DOWN:  sleeping = 1'b1;
            PM_TOTAL: in_total = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/cmpchg_unit.sv
module cmpchg_unit
    import cmpchg_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = $clog2(NCH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  cmp_raw,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [RD_W-1:0] rd_data,
    input  logic            sleep_go,
    input  logic [1:0]      sleep_kind,
    input  logic            ext_wake,
    output logic            irq,
    output logic            wake_req,
    output logic [1:0]      pm_state,
    output logic [NCH-1:0]  cmp_pin
);
    ch_cfg_t          cfg [NCH];
    logic [NCH-1:0]   clr_v, flag_v, lvl_v, act_v, wsrc_v, ie_v, oe_v;
    logic             all_off, sleeping, in_total;
    pm_state_t        st;

    cmpchg_regs #(.NCH(NCH), .AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .flag_in(flag_v),
        .lvl_in(lvl_v), .rd_data(rd_data), .cfg(cfg), .clr(clr_v),
        .all_off(all_off)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign ie_v[i]  = cfg[i].ie;
            assign oe_v[i]  = cfg[i].oe;
            assign act_v[i] = cfg[i].en & ~all_off & ~in_total;

            cmpchg_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk(clk), .rst_n(rst_n), .d(cmp_raw[i]), .q(lvl_v[i])
            );

            cmpchg_chan i_chan (
                .clk(clk), .rst_n(rst_n), .raw(cmp_raw[i]), .lvl(lvl_v[i]),
                .active(act_v[i]), .clr(clr_v[i]), .flag(flag_v[i]),
                .wake_src(wsrc_v[i])
            );

            assign cmp_pin[i] = oe_v[i] & act_v[i] & lvl_v[i];
        end
    endgenerate

    assign irq      = ~in_total & (|(flag_v & ie_v));
    assign wake_req = sleeping & ((|(wsrc_v & ie_v)) | irq);

    cmpchg_pwr i_pwr (
        .clk(clk), .rst_n(rst_n), .sleep_go(sleep_go), .sleep_kind(sleep_kind),
        .wake_any(wake_req), .ext_wake(ext_wake), .state(st),
        .sleeping(sleeping), .in_total(in_total)
    );

    assign pm_state = st;
endmodule

// File: rtl/cmpchg_chk.sv
module cmpchg_chk
    import cmpchg_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  act,
    input logic [NCH-1:0]  lvl,
    input logic [NCH-1:0]  flag,
    input logic [NCH-1:0]  oe,
    input logic [NCH-1:0]  pin,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [WR_W-1:0] wr_data,
    input logic            irq,
    input logic            wake_req,
    input logic [1:0]      pm_state,
    input logic            ext_wake
);
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            a_r1_flag_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
                (act[g] && (lvl[g] != $past(lvl[g]))) |=> flag[g]);

            a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[g] && !(wr_en && (wr_addr == AW'(g)) && !wr_data[BIT_FLAG]))
                |=> flag[g]);

            a_r7_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
                !(oe[g] && act[g]) |-> !pin[g]);
        end
    endgenerate

    a_r10_total_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_TOTAL) |-> (!irq && !wake_req));

    a_r10_total_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_TOTAL && !ext_wake) |=> (pm_state == PM_TOTAL));

    a_r9_wake_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (pm_state == PM_IDLE || pm_state == PM_DOWN));
endmodule

bind cmpchg_unit cmpchg_chk #(.NCH(NCH), .AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .act(act_v), .lvl(lvl_v), .flag(flag_v),
    .oe(oe_v), .pin(cmp_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .wake_req(wake_req), .pm_state(pm_state),
    .ext_wake(ext_wake)
);

// File: tb/test_cmpchg_unit.sv
module test_cmpchg_unit;
    localparam int NCH = 2;
    localparam int AW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cmp_raw = '0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [3:0]     wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [4:0]     rd_data;
    logic           sleep_go = 1'b0;
    logic [1:0]     sleep_kind = '0;
    logic           ext_wake = 1'b0;
    logic           irq, wake_req;
    logic [1:0]     pm_state;
    logic [NCH-1:0] cmp_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cmpchg_unit #(.NCH(NCH), .SYNC_STAGES(2), .AW(AW)) i_cmpchg_unit (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sleep_go(sleep_go), .sleep_kind(sleep_kind),
        .ext_wake(ext_wake), .irq(irq), .wake_req(wake_req),
        .pm_state(pm_state), .cmp_pin(cmp_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 4'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [4:0] v);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep(input int kind);
        @(negedge clk);
        sleep_go = 1'b1; sleep_kind = 2'(kind);
        @(negedge clk);
        sleep_go = 1'b0;
    endtask

    task automatic pulse_ext;
        @(negedge clk);
        ext_wake = 1'b1;
        @(negedge clk);
        ext_wake = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        rd(0, v); check(v == 0, "R11 reset ch0 reg", v, 0);
        rd(2, v); check(v == 0, "R11 reset global reg", v, 0);
        check(irq == 0 && pm_state == 0 && cmp_pin == 0, "R3 reset outputs",
              {irq, pm_state, cmp_pin}, 0);

        // R1 R2 R3: sweep channel, interrupt enable, edge direction
        for (int ch = 0; ch < NCH; ch++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    wr(0, 0); wr(1, 0);
                    cmp_raw[ch] = ~1'(dir);
                    idle(4);
                    wr(ch, 1 | (ie << 2));
                    cmp_raw[ch] = 1'(dir);
                    idle(2);
                    rd(ch, v); check(v[3] == 0, "R1 flag not before third edge", v[3], 0);
                    idle(1);
                    rd(ch, v); check(v[3] == 1, "R1 R2 flag set on toggle", v[3], 1);
                    check(v[4] == 1'(dir), "R11 level bit", v[4], dir);
                    rd(1 - ch, v); check(v[3] == 0, "R1 other channel untouched", v[3], 0);
                    check(irq == 1'(ie), "R3 irq follows flag and enable", irq, ie);
                    idle(3);
                    check(irq == 1'(ie), "R3 irq held", irq, ie);
                    wr(ch, 1 | (ie << 2));
                    check(irq == 0, "R3 irq drops on clear", irq, 0);
                end
            end
        end

        // R4: clear meets change in one cycle
        wr(1, 0);
        wr(0, 1);
        idle(3);
        @(negedge clk);
        cmp_raw[0] = ~cmp_raw[0];
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 0; wr_data = 4'h1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(0, v); check(v[3] == 1, "R4 change wins over clear", v[3], 1);
        wr(0, 4'h9);
        rd(0, v); check(v[3] == 1, "R4 write one keeps flag", v[3], 1);
        wr(0, 4'h1);
        rd(0, v); check(v[3] == 0, "R4 write zero clears flag", v[3], 0);

        // R5 R6 R7: global off
        cmp_raw[0] = 1'b0;
        idle(4);
        wr(0, 1);
        wr(2, 1);
        rd(2, v); check(v == 1, "R11 global reg readback", v, 1);
        wr(0, 7);
        cmp_raw[0] = 1'b1;
        idle(4);
        rd(0, v); check(v[3] == 0, "R5 no flag while off", v[3], 0);
        check(cmp_pin[0] == 0 && irq == 0, "R5 pin and irq quiet while off",
              {cmp_pin[0], irq}, 0);
        wr(2, 0);
        idle(3);
        rd(0, v); check(v[3] == 0, "R6 no false flag on turn-on", v[3], 0);
        check(cmp_pin[0] == 1, "R7 pin follows level", cmp_pin[0], 1);

        // R7 sweep: enable x pin enable x level per channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int en = 0; en < 2; en++) begin
                for (int oe = 0; oe < 2; oe++) begin
                    for (int lv = 0; lv < 2; lv++) begin
                        wr(ch, en | (oe << 1));
                        cmp_raw[ch] = 1'(lv);
                        idle(3);
                        check(cmp_pin[ch] == 1'(en & oe & lv), "R7 pin gating",
                              cmp_pin[ch], en & oe & lv);
                    end
                end
            end
        end

        // R8 R9: power states
        wr(0, 1 | 4); wr(1, 0);
        idle(4);
        wr(0, 1 | 4);
        go_sleep(0);
        check(pm_state == 0, "R8 code zero ignored", pm_state, 0);
        go_sleep(1);
        check(pm_state == 1, "R8 enter idle", pm_state, 1);
        check(wake_req == 0, "R9 no wake while steady", wake_req, 0);
        cmp_raw[0] = ~cmp_raw[0];
        #1;
        check(wake_req == 1, "R9 immediate wake in idle", wake_req, 1);
        @(negedge clk);
        check(pm_state == 0, "R9 idle to run", pm_state, 0);
        idle(3);
        wr(0, 1 | 4);
        check(irq == 0, "R3 cleared after wake", irq, 0);

        go_sleep(2);
        check(pm_state == 2, "R8 enter down", pm_state, 2);
        pulse_ext;
        check(pm_state == 0, "R9 external wake from down", pm_state, 0);
        go_sleep(2);
        cmp_raw[0] = ~cmp_raw[0];
        #1;
        check(wake_req == 1, "R9 immediate wake in down", wake_req, 1);
        @(negedge clk);
        check(pm_state == 0, "R9 down to run", pm_state, 0);
        idle(3);
        check(irq == 1, "R3 pending after wake", irq, 1);

        // R10: total power-down with a flag still pending
        go_sleep(3);
        check(pm_state == 3, "R8 enter total", pm_state, 3);
        check(irq == 0, "R10 irq masked in total", irq, 0);
        pulse_ext;
        check(irq == 1, "R10 irq back after total", irq, 1);
        wr(0, 1 | 4);
        go_sleep(3);
        cmp_raw[0] = ~cmp_raw[0];
        #1;
        check(wake_req == 0, "R10 no wake in total", wake_req, 0);
        idle(5);
        rd(0, v); check(v[3] == 0, "R10 no flag in total", v[3], 0);
        check(pm_state == 3 && irq == 0, "R10 state held", {irq, pm_state}, 3);
        pulse_ext;
        check(pm_state == 0, "R10 external exit", pm_state, 0);
        idle(3);
        rd(0, v); check(v[3] == 0, "R6 no false flag after total", v[3], 0);

        // R11 channel readback
        wr(1, 6);
        rd(1, v); check(v[3:0] == 4'h6, "R11 channel fields", v[3:0], 6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule